// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Time and Kill

This block is a single up-counting timer whose count also drives a pair of complementary PWM lines. The counter runs from zero up to a programmable terminal value. On reaching it, the counter either wraps to zero and keeps going or halts and drops its running flag. A compare value sets the duty cycle. A dead-time setting holds off the rising edge of each line until the other line has been low for that many clocks, so the two lines are never high together. A capture strobe records the current count.

A kill input overrides both lines at once through a combinational path, driving them to two configured safe levels. Once kill is released, both lines stay low until the next period boundary, so the waveform comes back with a whole period. The block sits under a motor-drive or power-stage controller, which holds the configuration steady and issues a start command to begin counting.

Top module: `tcpwm_dt`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, count and capture read 0, running, tc_pulse and cmp_pulse read 0, and pwm_p reads 0 unless kill is high.
- R2: A cycle with start high leaves count at 0 and running at 1 after the next edge. This takes priority over any counting in that cycle.
- R3: While running, each edge with cnt_en high and start low adds one to count. An edge with cnt_en low leaves count unchanged.
- R4: An advancing edge where count equals cfg_period raises tc_pulse for exactly the following cycle. With cfg_oneshot at 0, that edge sets count to 0 and running stays 1.
- R5: With cfg_oneshot at 1, the advancing edge at count equal to cfg_period leaves count at cfg_period and sets running to 0. Later edges leave it idle until start.
- R6: The undelayed PWM level is 1 while running and count < cfg_compare, and 0 otherwise. So cfg_compare of 0 keeps pwm_p low, and cfg_compare greater than cfg_period keeps it high except during dead time.
- R7: An advancing edge where count equals cfg_compare raises cmp_pulse for exactly the following cycle.
- R8: A line falls in the cycle after the undelayed level changes away from it. It rises only once the level has been steady for cfg_dead edges, which makes pwm_p and pwm_n never both high when kill is low. With cfg_dead of 0, the lines are exact complements one cycle after the level.
- R9: An edge with cap_strobe high loads capture with the count held before that edge. This includes an edge where count reloads or starts.
- R10: While kill is high, pwm_p equals cfg_kill_p and pwm_n equals cfg_kill_n in the same cycle, with no clock edge in between.
- R11: After kill falls, both lines stay 0 until an edge that produces a tc_pulse, or a start edge, with kill low. Dead-time gating then applies as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 16 | Terminal count value |
| cfg_compare | input | 16 | Duty-cycle compare value |
| cfg_dead | input | 8 | Dead time in clocks |
| cfg_oneshot | input | 1 | 1 = halt at terminal count, 0 = wrap to zero |
| cfg_kill_p | input | 1 | Level of pwm_p while kill is high |
| cfg_kill_n | input | 1 | Level of pwm_n while kill is high |
| cnt_en | input | 1 | Count enable |
| cap_strobe | input | 1 | Capture event |
| kill | input | 1 | Output override |
| start | input | 1 | Clear count and begin running |
| pwm_p | output | 1 | True PWM line |
| pwm_n | output | 1 | Complementary PWM line |
| tc_pulse | output | 1 | Terminal-count pulse |
| cmp_pulse | output | 1 | Compare-match pulse |
| count | output | 16 | Current count |
| capture | output | 16 | Last captured count |
| running | output | 1 | Counter active |

## Verification
The hardest case to reach is a capture strobe on the very edge where the counter reloads. Here the captured value must be the terminal count, not zero. The stimulus watches count at each falling edge and raises cap_strobe for one cycle once count equals cfg_period. A similar timing lock places kill in the middle of a period and releases it before the boundary, which shows the lines held low until the terminal count. A reference model built on integers is checked against every output on every clock. It also covers a dead time longer than the high phase, a compare of zero, a compare above the period, and one-shot runs.

// File: rtl/tcpwm_dt.sv
module tcpwm_dt #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_compare,
  input  logic [DW-1:0] cfg_dead,
  input  logic          cfg_oneshot,
  input  logic          cfg_kill_p,
  input  logic          cfg_kill_n,
  input  logic          cnt_en,
  input  logic          cap_strobe,
  input  logic          kill,
  input  logic          start,
  output logic          pwm_p,
  output logic          pwm_n,
  output logic          tc_pulse,
  output logic          cmp_pulse,
  output logic [CW-1:0] count,
  output logic [CW-1:0] capture,
  output logic          running
);
  localparam logic [DW-1:0] AGE_MAX = {DW{1'b1}};

  logic [CW-1:0] cnt_q, cap_q;
  logic [DW-1:0] age_q;
  logic          run_q, lvl_q, hold_q, tc_q, cm_q;

  wire adv    = run_q & cnt_en & ~start;
  wire at_end = (cnt_q == cfg_period);
  wire tc_now = adv & at_end;
  wire raw    = run_q & (cnt_q < cfg_compare);
  wire ripe   = (age_q >= cfg_dead);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (adv) begin
      if (!at_end)          cnt_q <= cnt_q + 1'b1;
      else if (cfg_oneshot) run_q <= 1'b0;
      else                  cnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cap_q <= '0;
    else if (cap_strobe) cap_q <= cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q <= 1'b0;
      cm_q <= 1'b0;
    end else begin
      tc_q <= tc_now;
      cm_q <= adv & (cnt_q == cfg_compare);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      age_q <= '0;
    end else begin
      lvl_q <= raw;
      if (raw != lvl_q)       age_q <= '0;
      else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  hold_q <= 1'b0;
    else if (kill)               hold_q <= 1'b1;
    else if (tc_now || start)    hold_q <= 1'b0;
  end

  assign pwm_p     = kill ? cfg_kill_p : (~hold_q &  lvl_q & ripe);
  assign pwm_n     = kill ? cfg_kill_n : (~hold_q & ~lvl_q & ripe);
  assign tc_pulse  = tc_q;
  assign cmp_pulse = cm_q;
  assign count     = cnt_q;
  assign capture   = cap_q;
  assign running   = run_q;
endmodule

module tcpwm_dt_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_period,
  input logic          cfg_oneshot,
  input logic          cfg_kill_p,
  input logic          cfg_kill_n,
  input logic          cnt_en,
  input logic          cap_strobe,
  input logic          kill,
  input logic          start,
  input logic          pwm_p,
  input logic          pwm_n,
  input logic          tc_pulse,
  input logic [CW-1:0] count,
  input logic [CW-1:0] capture,
  input logic          running
);
  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0) && running);

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !start) |=> $stable(count));

  // R4
  wrap_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !$past(cfg_oneshot) && $past(rst_n)) |-> (count == '0) && running);

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && $past(cfg_oneshot) && $past(rst_n)) |-> !running && (count == $past(cfg_period)));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kill |-> !(pwm_p && pwm_n));

  // R9
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && rst_n) |=> capture == $past(count));

  // R10
  kill_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (pwm_p == cfg_kill_p) && (pwm_n == cfg_kill_n));

  // R11
  post_kill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(kill) && !tc_pulse) |-> !pwm_p && !pwm_n);
endmodule

bind tcpwm_dt tcpwm_dt_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_oneshot(cfg_oneshot),
  .cfg_kill_p(cfg_kill_p), .cfg_kill_n(cfg_kill_n), .cnt_en(cnt_en),
  .cap_strobe(cap_strobe), .kill(kill), .start(start), .pwm_p(pwm_p),
  .pwm_n(pwm_n), .tc_pulse(tc_pulse), .count(count), .capture(capture),
  .running(running)
);

// File: tb/tcpwm_dt_test.sv
module tcpwm_dt_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] cfg_period = 16'd9, cfg_compare = 16'd4;
  logic [7:0]  cfg_dead = 8'd2;
  logic        cfg_oneshot = 1'b0, cfg_kill_p = 1'b1, cfg_kill_n = 1'b0;
  logic        cnt_en = 1'b0, cap_strobe = 1'b0, kill = 1'b0, start = 1'b0;
  logic        pwm_p, pwm_n, tc_pulse, cmp_pulse, running;
  logic [15:0] count, capture;

  tcpwm_dt uut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_compare(cfg_compare),
    .cfg_dead(cfg_dead), .cfg_oneshot(cfg_oneshot), .cfg_kill_p(cfg_kill_p),
    .cfg_kill_n(cfg_kill_n), .cnt_en(cnt_en), .cap_strobe(cap_strobe),
    .kill(kill), .start(start), .pwm_p(pwm_p), .pwm_n(pwm_n),
    .tc_pulse(tc_pulse), .cmp_pulse(cmp_pulse), .count(count),
    .capture(capture), .running(running)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string phase = "R1";

  int m_cnt, m_cap, m_age;
  bit m_run, m_lvl, m_hold, m_tc, m_cm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_age = 0;
      m_run = 0; m_lvl = 0; m_hold = 0; m_tc = 0; m_cm = 0;
    end else begin
      bit adv, tcn, rw;
      int n_cnt; bit n_run;
      adv = m_run && cnt_en && !start;
      tcn = adv && (m_cnt == int'(cfg_period));
      rw  = m_run && (m_cnt < int'(cfg_compare));
      if (cap_strobe) m_cap = m_cnt;
      m_cm = adv && (m_cnt == int'(cfg_compare));
      if (kill) m_hold = 1;
      else if (tcn || start) m_hold = 0;
      if (rw != m_lvl) m_age = 0;
      else if (m_age < 255) m_age = m_age + 1;
      m_lvl = rw;
      n_cnt = m_cnt; n_run = m_run;
      if (start) begin n_cnt = 0; n_run = 1; end
      else if (adv) begin
        if (m_cnt != int'(cfg_period)) n_cnt = m_cnt + 1;
        else if (cfg_oneshot) n_run = 0;
        else n_cnt = 0;
      end
      m_cnt = n_cnt; m_run = n_run; m_tc = tcn;
    end
  end

  task automatic chk(string req, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", req, phase, what, act, exp_v, $time);
    end
  endtask

  task automatic compare_all();
    bit ep, en;
    ep = kill ? cfg_kill_p : (!m_hold && m_lvl && (m_age >= int'(cfg_dead)));
    en = kill ? cfg_kill_n : (!m_hold && !m_lvl && (m_age >= int'(cfg_dead)));
    chk("R3", int'(count), m_cnt, "count");
    chk("R5", int'(running), int'(m_run), "running");
    chk("R4", int'(tc_pulse), int'(m_tc), "tc_pulse");
    chk("R7", int'(cmp_pulse), int'(m_cm), "cmp_pulse");
    chk("R9", int'(capture), m_cap, "capture");
    chk(kill ? "R10" : "R8", int'(pwm_p), int'(ep), "pwm_p");
    chk(kill ? "R10" : "R8", int'(pwm_n), int'(en), "pwm_n");
    if (!kill && pwm_p && pwm_n) chk("R8", 1, 0, "overlap");
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1 reset state
    step(3);
    chk("R1", int'(count), 0, "reset count");
    chk("R1", int'(running), 0, "reset running");
    rst_n = 1'b1;
    step(1);
    chk("R1", int'(pwm_p), 0, "post-reset pwm_p");

    // R2 R3 R4 R6 R7 R8 auto-reload with dead time 2
    phase = "R2"; cnt_en = 1'b1;
    pulse_start();
    chk("R2", int'(running), 1, "running after start");
    phase = "R6"; step(40);

    // R3 gated enable
    phase = "R3";
    for (int i = 0; i < 30; i++) begin cnt_en = (i % 3) != 1; step(1); end
    cnt_en = 1'b1;

    // R8 zero dead time, then dead time longer than high phase
    phase = "R8"; cfg_dead = 8'd0; step(25);
    cfg_dead = 8'd6; step(25);
    cfg_dead = 8'd1; step(12);

    // R9 captures, including on the reload edge
    phase = "R9";
    cap_strobe = 1'b1; step(1); cap_strobe = 1'b0; step(3);
    while (count != cfg_period) step(1);
    cap_strobe = 1'b1; step(1); cap_strobe = 1'b0;
    chk("R9", int'(capture), int'(cfg_period), "capture at reload");
    step(4);

    // R10 R11 kill mid-period
    phase = "R10";
    while (count != 16'd2) step(1);
    kill = 1'b1; #1;
    chk("R10", int'(pwm_p), 1, "immediate kill p");
    chk("R10", int'(pwm_n), 0, "immediate kill n");
    step(5);
    phase = "R11"; kill = 1'b0; step(25);
    phase = "R10"; cfg_kill_p = 1'b0; cfg_kill_n = 1'b1;
    kill = 1'b1; step(3); kill = 1'b0;
    phase = "R11"; step(20);

    // R6 compare extremes
    phase = "R6"; cfg_compare = 16'd0; step(25);
    cfg_compare = 16'd12; step(25);
    cfg_compare = 16'd5; cfg_period = 16'd7; step(20);

    // R5 one-shot
    phase = "R5"; cfg_oneshot = 1'b1; pulse_start(); step(15);
    chk("R5", int'(running), 0, "stopped after one-shot");
    chk("R5", int'(count), 7, "held at period");
    pulse_start(); step(4);

    // R2 start mid-count restarts
    phase = "R2"; cfg_oneshot = 1'b0; step(3);
    pulse_start();
    chk("R2", int'(count), 0, "restart clears count");
    step(20);

    summary();
  end
endmodule